// File: doc/BRIEF.md
# UART FIFO Control and DMA Ready Signalling

This block holds the FIFO configuration for one UART channel whose transmit and receive FIFOs are 16 entries deep. It also produces the two active-low DMA handshake outputs, transmit-ready and receive-ready. The host writes one 8-bit configuration byte. The block reads the current fill counts of both FIFOs and returns several results:

- the FIFO enable;
- one-cycle clear pulses for each FIFO;
- the selected transfer mode;
- the receive trigger level as a byte count;
- a read-back image of the configuration;
- the two ready pins.

The clear pulses only empty the FIFO storage and counters. The serial shift registers are not touched.

The ready pins have two rules, and the transfer mode picks between them:

- **Single-character mode** signals one character at a time.
- **Block mode** keeps a pin active as long as a whole run of transfers can continue.

Block mode takes effect only while the FIFOs are enabled. A separate pin-function select decides whether the receive-ready function appears on its pin at all.

The clear sequencer has two states:

- `CLR_IDLE` moves to `CLR_FIRE` on a qualifying write.
- `CLR_FIRE` stays in `CLR_FIRE` on another such write and otherwise returns to `CLR_IDLE`.

Each ready pin also has two states:

- `PIN_IDLE` moves to `PIN_ACTIVE` when the ready condition holds at a clock edge.
- `PIN_ACTIVE` returns to `PIN_IDLE` when the condition is false at an edge.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the FIFO enable is 0, the transfer mode is single-character, the trigger code is 00, both clear pulses are 0, and both ready pins are high.
- R2: On a write, bit 0 is always stored as the FIFO enable. Bit 3 and bits 7:6 are stored only when bit 0 of the same write is 1; otherwise they keep their previous values.
- R3: A write with bits 0 and 1 both set raises `rx_fifo_clr` for exactly one cycle, in the cycle after the write edge. Read-back bit 1 is always 0.
- R4: A write with bits 0 and 2 both set raises `tx_fifo_clr` for exactly one cycle, in the cycle after the write edge. Read-back bit 2 is always 0. A write with bit 0 clear produces no pulse.
- R5: Bit 3 selects the transfer mode: 0 means single-character and 1 means block. Block rules apply only while the FIFO enable is 1.
- R6: Bits 7:6 give the receive trigger as 00 = 1, 01 = 4, 10 = 8, 11 = 14 bytes. The read-back image is {trigger[1:0], 2'b00, mode, 1'b0, 1'b0, enable}, so bits 5:4 always read 0.
- R7: Under single-character rules, `txrdy_n` is low exactly when the transmit count is 0. `rxrdy_n` is low exactly when the receive count is nonzero.
- R8: Under block rules, `txrdy_n` is low exactly when the transmit count is below 16. `rxrdy_n` is low exactly when the receive count is at or above the trigger level, up to a count of 16.
- R9: `rxrdy_n` stays high whenever `rxrdy_pin_sel` is 0.
- R10: Both ready pins are registered. Each reflects the counts, configuration and pin select sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the configuration byte |
| wr_data | input | 8 | Configuration byte being written |
| tx_count | input | 5 | Current transmit FIFO fill count (0 to 16) |
| rx_count | input | 5 | Current receive FIFO fill count (0 to 16) |
| rxrdy_pin_sel | input | 1 | 1 routes the receive-ready function to its pin |
| cfg_image | output | 8 | Read-back image of the configuration |
| fifo_en | output | 1 | FIFO enable |
| rx_fifo_clr | output | 1 | One-cycle clear pulse for the receive FIFO |
| tx_fifo_clr | output | 1 | One-cycle clear pulse for the transmit FIFO |
| dma_mode | output | 1 | Stored transfer mode (0 single-character, 1 block) |
| rx_trig_lvl | output | 5 | Receive trigger level in bytes |
| txrdy_n | output | 1 | Active-low transmit-ready |
| rxrdy_n | output | 1 | Active-low receive-ready |

## Verification
Some properties are checked by assertions on every cycle:

- Each clear pulse must trace back to a qualifying write.
- A write with the enable bit clear must leave the mode and trigger fields unchanged.
- A full transmit FIFO under block rules, or any pending transmit data under single-character rules, must deassert transmit-ready on the next cycle.
- A deselected receive-ready pin must stay high.

Other behaviour is shown only by the bench scenarios, which compare against a behavioural model:

- the exact trigger-level thresholds for each code;
- the fallback to single-character rules when the FIFOs are disabled;
- exactly one pulse per clearing write, including back-to-back writes;
- the read-back image with its reserved bits.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_BLOCK  = 1'b1
    } xfer_mode_e;

    typedef enum logic {
        CLR_IDLE = 1'b0,
        CLR_FIRE = 1'b1
    } clr_state_e;

    typedef enum logic {
        PIN_IDLE   = 1'b0,
        PIN_ACTIVE = 1'b1
    } pin_state_e;

    // Bit positions inside the written configuration byte
    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned RXCLR_BIT = 1;
    localparam int unsigned TXCLR_BIT = 2;
    localparam int unsigned MODE_BIT  = 3;
    localparam int unsigned TRIG_LSB  = 6;

    typedef struct packed {
        logic [1:0] trig;
        xfer_mode_e mode;
        logic       en;
    } cfg_t;

    // Trigger byte count derived from the FIFO depth
    function automatic int unsigned trig_level(input logic [1:0] code,
                                               input int unsigned depth);
        int unsigned lvl;
        unique case (code)
            2'b00:   lvl = 1;
            2'b01:   lvl = depth / 4;
            2'b10:   lvl = depth / 2;
            default: lvl = depth - 2;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/ufc_cfg_reg.sv
module ufc_cfg_reg
    import ufc_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output cfg_t          cfg_o,
    output logic          rx_clr_o,
    output logic          tx_clr_o
);

    cfg_t       cfg_q;
    clr_state_e clr_state;
    clr_state_e clr_next;
    logic       rx_pend_q;
    logic       tx_pend_q;
    logic       fire;
    logic       unused_rsvd_bits;

    assign unused_rsvd_bits = ^{wr_data[5:4], wr_data[DW-1:DW-1]};

    assign fire = wr_en && wr_data[EN_BIT]
                  && (wr_data[RXCLR_BIT] || wr_data[TXCLR_BIT]);

    // Configuration storage: enable always, the rest only with enable set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{trig: 2'b00, mode: XFER_SINGLE, en: 1'b0};
        end else if (wr_en) begin
            cfg_q.en <= wr_data[EN_BIT];
            if (wr_data[EN_BIT]) begin
                cfg_q.mode <= xfer_mode_e'(wr_data[MODE_BIT]);
                cfg_q.trig <= wr_data[TRIG_LSB +: 2];
            end
        end
    end

    // Clear sequencer state register and pending flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_state <= CLR_IDLE;
            rx_pend_q <= 1'b0;
            tx_pend_q <= 1'b0;
        end else begin
            clr_state <= clr_next;
            rx_pend_q <= fire && wr_data[RXCLR_BIT];
            tx_pend_q <= fire && wr_data[TXCLR_BIT];
        end
    end

    always_comb begin
        clr_next = clr_state;
        unique case (clr_state)
            CLR_IDLE: clr_next = fire ? CLR_FIRE : CLR_IDLE;
            CLR_FIRE: clr_next = fire ? CLR_FIRE : CLR_IDLE;
            default:  clr_next = CLR_IDLE;
        endcase
    end

    // Output process of the clear sequencer
    always_comb begin
        rx_clr_o = 1'b0;
        tx_clr_o = 1'b0;
        unique case (clr_state)
            CLR_IDLE: begin
                rx_clr_o = 1'b0;
                tx_clr_o = 1'b0;
            end
            CLR_FIRE: begin
                rx_clr_o = rx_pend_q;
                tx_clr_o = tx_pend_q;
            end
            default: begin
                rx_clr_o = 1'b0;
                tx_clr_o = 1'b0;
            end
        endcase
    end

    assign cfg_o = cfg_q;

    // R2
    keep_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[EN_BIT]) |=> ($stable(cfg_q.mode) && $stable(cfg_q.trig)));

    // R3
    rxclr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr_o |-> $past(wr_en && wr_data[EN_BIT] && wr_data[RXCLR_BIT]));

    // R4
    txclr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr_o |-> $past(wr_en && wr_data[EN_BIT] && wr_data[TXCLR_BIT]));

endmodule

// File: rtl/ufc_rdy_pin.sv
module ufc_rdy_pin
    import ufc_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5,
    parameter bit          IS_RX = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  xfer_mode_e       mode,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig,
    input  logic             pin_sel,
    output logic             rdy_n_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    pin_state_e state;
    pin_state_e state_next;
    logic       want_single;
    logic       want_block;
    logic       gate;
    logic       block_rules;
    logic       want;

    generate
        if (IS_RX) begin : g_rx
            assign want_single = (count != '0);
            assign want_block  = (count >= trig);
            assign gate        = pin_sel;
        end else begin : g_tx
            logic unused_tx_inputs;
            assign unused_tx_inputs = ^{trig, pin_sel};
            assign want_single = (count == '0);
            assign want_block  = (count < FULL_CNT);
            assign gate        = 1'b1;
        end
    endgenerate

    assign block_rules = fifo_en && (mode == XFER_BLOCK);
    assign want        = gate && (block_rules ? want_block : want_single);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PIN_IDLE;
        else        state <= state_next;
    end

    always_comb begin
        state_next = state;
        unique case (state)
            PIN_IDLE:   state_next = want ? PIN_ACTIVE : PIN_IDLE;
            PIN_ACTIVE: state_next = want ? PIN_ACTIVE : PIN_IDLE;
            default:    state_next = PIN_IDLE;
        endcase
    end

    always_comb begin
        rdy_n_o = 1'b1;
        unique case (state)
            PIN_IDLE:   rdy_n_o = 1'b1;
            PIN_ACTIVE: rdy_n_o = 1'b0;
            default:    rdy_n_o = 1'b1;
        endcase
    end

    generate
        if (IS_RX) begin : g_rx_chk
            // R9
            pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !pin_sel |=> rdy_n_o);
        end else begin : g_tx_chk
            // R8
            tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fifo_en && mode == XFER_BLOCK && count == FULL_CNT) |=> rdy_n_o);
            // R7
            tx_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!fifo_en && count != '0) |=> rdy_n_o);
        end
    endgenerate

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import ufc_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rxrdy_pin_sel,
    output logic [7:0]       cfg_image,
    output logic             fifo_en,
    output logic             rx_fifo_clr,
    output logic             tx_fifo_clr,
    output logic             dma_mode,
    output logic [CNT_W-1:0] rx_trig_lvl,
    output logic             txrdy_n,
    output logic             rxrdy_n
);

    localparam int unsigned NUM_PINS = 2;

    cfg_t             cfg;
    logic [CNT_W-1:0] pin_count [NUM_PINS];
    logic             pin_rdy_n [NUM_PINS];

    ufc_cfg_reg #(.DW(8)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cfg_o    (cfg),
        .rx_clr_o (rx_fifo_clr),
        .tx_clr_o (tx_fifo_clr)
    );

    assign rx_trig_lvl = CNT_W'(trig_level(cfg.trig, DEPTH));
    assign fifo_en     = cfg.en;
    assign dma_mode    = cfg.mode;
    assign cfg_image   = {cfg.trig, 2'b00, cfg.mode, 1'b0, 1'b0, cfg.en};

    assign pin_count[0] = tx_count;
    assign pin_count[1] = rx_count;

    // Index 0 drives transmit-ready, index 1 receive-ready
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        ufc_rdy_pin #(
            .DEPTH (DEPTH),
            .CNT_W (CNT_W),
            .IS_RX (g == 1)
        ) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .fifo_en (cfg.en),
            .mode    (cfg.mode),
            .count   (pin_count[g]),
            .trig    (rx_trig_lvl),
            .pin_sel (rxrdy_pin_sel),
            .rdy_n_o (pin_rdy_n[g])
        );
    end

    assign txrdy_n = pin_rdy_n[0];
    assign rxrdy_n = pin_rdy_n[1];

endmodule

// File: tb/tb_uart_fifo_ctl.sv
module tb_uart_fifo_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [4:0] tx_count = 5'd0;
    logic [4:0] rx_count = 5'd0;
    logic       rxrdy_pin_sel = 1'b1;
    logic [7:0] cfg_image;
    logic       fifo_en;
    logic       rx_fifo_clr;
    logic       tx_fifo_clr;
    logic       dma_mode;
    logic [4:0] rx_trig_lvl;
    logic       txrdy_n;
    logic       rxrdy_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_fifo_ctl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .tx_count      (tx_count),
        .rx_count      (rx_count),
        .rxrdy_pin_sel (rxrdy_pin_sel),
        .cfg_image     (cfg_image),
        .fifo_en       (fifo_en),
        .rx_fifo_clr   (rx_fifo_clr),
        .tx_fifo_clr   (tx_fifo_clr),
        .dma_mode      (dma_mode),
        .rx_trig_lvl   (rx_trig_lvl),
        .txrdy_n       (txrdy_n),
        .rxrdy_n       (rxrdy_n)
    );

    // Behavioural reference model
    logic       m_en = 1'b0;
    logic       m_mode = 1'b0;
    logic [1:0] m_trig = 2'b00;
    logic       e_rxclr = 1'b0;
    logic       e_txclr = 1'b0;
    logic       e_txrdy_n = 1'b1;
    logic       e_rxrdy_n = 1'b1;

    function automatic int trig_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic model_tx_n(input logic en, input logic md, input int t);
        if (en && md) return !(t < 16);
        return !(t == 0);
    endfunction

    function automatic logic model_rx_n(input logic en, input logic md, input logic [1:0] tc,
                                        input int r, input logic sel);
        if (!sel) return 1'b1;
        if (en && md) return !(r >= trig_bytes(tc));
        return !(r != 0);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en <= 1'b0; m_mode <= 1'b0; m_trig <= 2'b00;
            e_rxclr <= 1'b0; e_txclr <= 1'b0;
            e_txrdy_n <= 1'b1; e_rxrdy_n <= 1'b1;
        end else begin
            e_txrdy_n <= model_tx_n(m_en, m_mode, int'(tx_count));
            e_rxrdy_n <= model_rx_n(m_en, m_mode, m_trig, int'(rx_count), rxrdy_pin_sel);
            e_rxclr   <= wr_en && wr_data[0] && wr_data[1];
            e_txclr   <= wr_en && wr_data[0] && wr_data[2];
            if (wr_en) begin
                m_en <= wr_data[0];
                if (wr_data[0]) begin
                    m_mode <= wr_data[3];
                    m_trig <= wr_data[7:6];
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check("R2 fifo_en", int'(fifo_en), int'(m_en));
            check("R5 dma_mode", int'(dma_mode), int'(m_mode));
            check("R6 trigger", int'(rx_trig_lvl), trig_bytes(m_trig));
            check("R6 image", int'(cfg_image), int'({m_trig, 2'b00, m_mode, 2'b00, m_en}));
            check("R3 rx clear", int'(rx_fifo_clr), int'(e_rxclr));
            check("R4 tx clear", int'(tx_fifo_clr), int'(e_txclr));
            // R7 / R8 / R10 transmit-ready timing and rules
            check("R10 txrdy_n", int'(txrdy_n), int'(e_txrdy_n));
            // R7 / R8 / R9 / R10 receive-ready timing and rules
            check("R10 rxrdy_n", int'(rxrdy_n), int'(e_rxrdy_n));
        end
    end

    task automatic write_cfg(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic set_counts(input int t, input int r);
        @(negedge clk);
        tx_count = 5'(t);
        rx_count = 5'(r);
        repeat (2) @(negedge clk);
    endtask

    task automatic count_pulses(input logic [7:0] d, input int exp_rx, input int exp_tx);
        int nrx = 0;
        int ntx = 0;
        write_cfg(d);
        for (int k = 0; k < 4; k++) begin
            if (rx_fifo_clr) nrx++;
            if (tx_fifo_clr) ntx++;
            @(negedge clk);
        end
        check("R3 rx pulse count", nrx, exp_rx);
        check("R4 tx pulse count", ntx, exp_tx);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 enable", int'(fifo_en), 0);
        check("R1 txrdy_n", int'(txrdy_n), 1);
        check("R1 rxrdy_n", int'(rxrdy_n), 1);
        check("R1 trigger", int'(rx_trig_lvl), 1);
        rst_n = 1'b1;

        // R7 single-character rules with FIFOs disabled
        for (int t = 0; t < 3; t++)
            for (int r = 0; r < 3; r++)
                set_counts(t, r);

        // R8 block rules, trigger 4
        write_cfg(8'b0100_1001);
        for (int i = 0; i <= 16; i++) set_counts(i, i);
        for (int i = 0; i <= 16; i++) set_counts(16 - i, i);

        // R2 write without enable: mode and trigger held, rules fall back (R5)
        write_cfg(8'b1111_0110);
        for (int i = 0; i < 5; i++) set_counts(i, i);
        check("R2 held mode", int'(dma_mode), 1);
        check("R2 held trigger", int'(rx_trig_lvl), 4);

        // R6 remaining trigger codes under block rules
        write_cfg(8'b1100_1001);
        for (int i = 11; i <= 16; i++) set_counts(15, i);
        write_cfg(8'b1000_1001);
        for (int i = 6; i <= 10; i++) set_counts(16, i);
        write_cfg(8'b0011_1001);
        check("R6 reserved bits", int'(cfg_image[5:4]), 0);
        for (int i = 0; i < 3; i++) set_counts(i, i);

        // R5 enabled with single-character mode
        write_cfg(8'b0000_0001);
        for (int i = 0; i < 4; i++) set_counts(i, 3 - i);

        // R3 / R4 clear pulses
        count_pulses(8'h03, 1, 0);
        count_pulses(8'h05, 0, 1);
        count_pulses(8'h07, 1, 1);
        count_pulses(8'h06, 0, 0);
        write_cfg(8'h03);
        write_cfg(8'h05);
        repeat (3) @(negedge clk);

        // R9 pin select off
        write_cfg(8'b0100_1001);
        rxrdy_pin_sel = 1'b0;
        for (int i = 0; i < 8; i++) set_counts(i, i * 2);
        check("R9 rxrdy_n deselected", int'(rxrdy_n), 1);
        rxrdy_pin_sel = 1'b1;
        set_counts(0, 10);
        check("R9 rxrdy_n reselected", int'(rxrdy_n), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule